// File: doc/BRIEF.md
# Paired-Counter PWM Generator

This block produces a pulse-width-modulated output from two 16-bit down-counters. The lead counter works as a free-running interval timer. Each time it wraps, it raises a one-cycle period interrupt and reloads from the period register. The follower counter is a one-shot. Every period event retriggers it from the duty register, and it shapes the output pulse. After it expires it holds at zero until the next event.

Both counters advance only on a count-clock enable tick, which is a single-cycle strobe in the system clock domain. Software sets the period and duty registers, pulses start to begin, and pulses stop to freeze everything. Register writes are sampled only at a period event, so a new period and duty pair always takes effect together. The output goes active one tick after the period event. It goes inactive when the follower reaches zero.

Top module: `pwm_pair`

## Requirements
- R1: While reset is asserted, and after it is released until the first start, `pwmOut` and `periodIrq` are 0.
- R2: A start pulse (with stop low) produces a `periodIrq` pulse in the next clock cycle and loads the lead counter from the period register. If start and stop are both high, stop wins.
- R3: While running, successive `periodIrq` pulses are separated by exactly P+1 ticks, where P is the period register value.
- R4: In each period, `pwmOut` rises on the tick after the period event and stays high for exactly D ticks, where D is the duty register value. `pwmOut` changes only on a system clock edge that carries a tick, start or stop.
- R5: D = 0 keeps `pwmOut` at 0 for the whole period.
- R6: D >= P+1 keeps `pwmOut` continuously at 1 across period boundaries. The high time never exceeds P+1 ticks per period.
- R7: Writes to the period or duty register take effect only at the next period event. The period in progress finishes with the old values.
- R8: Stop forces `pwmOut` to 0 on the next clock and suppresses all `periodIrq` pulses until the next start. A later start restarts the sequence from the current register values.
- R9: `periodIrq` is high for one system clock cycle per period event. It never stays high across a clock in which no tick or start occurred.
- R10: With no tick, the counters and `pwmOut` hold their values and no `periodIrq` is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-clock enable, one cycle wide |
| startReq | input | 1 | Start pulse; raises an event and loads both counters |
| stopReq | input | 1 | Stop pulse; freezes counters and forces output low |
| periodWrEn | input | 1 | Write strobe for the period register |
| periodWrData | input | 16 | New period value P |
| dutyWrEn | input | 1 | Write strobe for the duty register |
| dutyWrData | input | 16 | New duty value D |
| periodIrq | output | 1 | One-cycle pulse at each period event |
| pwmOut | output | 1 | PWM waveform, active high |

## Verification
The hardest situation to reach from the ports is a register rewrite that falls inside a period. The bench has to show that the old period and duty finish first and the new pair then applies together. The stimulus waits for a period interrupt, lets a few ticks pass, and then rewrites both registers. It then measures the tick count and high-tick count of the next two periods separately. Boundary duties (zero, exactly P+1, and far above it) are run with ticks spaced one, two and three clocks apart, so that events with and without idle cycles between ticks are both covered.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int CNT_W = 16;

  typedef struct packed {
    logic loadCnt;   // period event: reload both counters
    logic stepCnt;   // ordinary tick: count down
    logic forceOff;  // drive output inactive
  } pwmStrobes_t;
endpackage

// File: rtl/pwm_pair_ctrl.sv
module pwm_pair_ctrl
  import pwm_pair_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        startReq,
  input  logic        stopReq,
  input  logic        masterZero,
  output pwmStrobes_t strobes,
  output logic        periodIrq
);
  logic running;
  logic startGo;
  logic tickEvent;
  logic tickStep;

  assign startGo   = startReq && !stopReq;
  assign tickEvent = running && tick && !stopReq && masterZero;
  assign tickStep  = running && tick && !stopReq && !masterZero && !startGo;

  always_comb begin
    strobes.loadCnt  = startGo || tickEvent;
    strobes.stepCnt  = tickStep;
    strobes.forceOff = startGo || stopReq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      periodIrq <= 1'b0;
    end else begin
      if (stopReq)      running <= 1'b0;
      else if (startGo) running <= 1'b1;
      periodIrq <= strobes.loadCnt;
    end
  end
endmodule

// File: rtl/pwm_pair_dp.sv
module pwm_pair_dp
  import pwm_pair_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  pwmStrobes_t  strobes,
  input  logic         periodWrEn,
  input  logic [W-1:0] periodWrData,
  input  logic         dutyWrEn,
  input  logic [W-1:0] dutyWrData,
  output logic         masterZero,
  output logic         pwmOut
);
  logic [W-1:0] periodReg;
  logic [W-1:0] dutyReg;
  logic [W-1:0] masterCnt;
  logic [W-1:0] slaveCnt;
  logic         slaveBusy;

  assign masterZero = (masterCnt == '0);
  assign slaveBusy  = (slaveCnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      periodReg <= '0;
      dutyReg   <= '0;
    end else begin
      if (periodWrEn) periodReg <= periodWrData;
      if (dutyWrEn)   dutyReg   <= dutyWrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      masterCnt <= '0;
      slaveCnt  <= '0;
    end else if (strobes.loadCnt) begin
      masterCnt <= periodReg;
      slaveCnt  <= dutyReg;
    end else if (strobes.stepCnt) begin
      masterCnt <= masterCnt - 1'b1;
      if (slaveBusy) slaveCnt <= slaveCnt - 1'b1;
    end
  end

  // Output reflects whether the one-shot still had ticks left at this tick.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   pwmOut <= 1'b0;
    else if (strobes.forceOff)                    pwmOut <= 1'b0;
    else if (strobes.loadCnt || strobes.stepCnt)  pwmOut <= slaveBusy;
  end
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
  import pwm_pair_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         startReq,
  input  logic         stopReq,
  input  logic         periodWrEn,
  input  logic [W-1:0] periodWrData,
  input  logic         dutyWrEn,
  input  logic [W-1:0] dutyWrData,
  output logic         periodIrq,
  output logic         pwmOut
);
  pwmStrobes_t strobes;
  logic        masterZero;

  pwm_pair_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .startReq(startReq),
    .stopReq(stopReq), .masterZero(masterZero), .strobes(strobes),
    .periodIrq(periodIrq)
  );

  pwm_pair_dp #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .periodWrEn(periodWrEn), .periodWrData(periodWrData),
    .dutyWrEn(dutyWrEn), .dutyWrData(dutyWrData),
    .masterZero(masterZero), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic startReq,
  input logic stopReq,
  input logic periodIrq,
  input logic pwmOut
);
  // R2
  start_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (startReq && !stopReq) |=> periodIrq);

  // R8
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopReq |=> (!pwmOut && !periodIrq));

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !startReq) |=> !periodIrq);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !startReq && !stopReq) |=> $stable(pwmOut));

  // R4
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwmOut) |-> $past(tick));
endmodule

bind pwm_pair pwm_pair_chk u_chk (.*);

// File: tb/pwm_pair_test.sv
`timescale 1ns/1ps
module pwm_pair_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, startReq = 1'b0, stopReq = 1'b0;
  logic periodWrEn = 1'b0, dutyWrEn = 1'b0;
  logic [15:0] periodWrData = '0, dutyWrData = '0;
  logic periodIrq, pwmOut;

  always #2.5 clk = ~clk;

  pwm_pair uut (.*);

  int vectors = 0, fails = 0, cycles = 0;
  bit tickOn = 0;
  int tickDiv = 1, tickPh = 0;

  // reference model state
  int pReg = 0, dReg = 0, mLeft = 0, sLeft = 0;
  bit run = 0, expPwm = 0, expIrq = 0;
  // measurement
  int ticksAcc = 0, highAcc = 0, lastTicks = -1, lastHigh = -1, irqCnt = 0;

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // tick generator, driven on the falling edge
  always @(negedge clk) begin
    if (tickOn) begin
      tickPh = (tickPh + 1) % tickDiv;
      tick <= (tickPh == 0);
    end else tick <= 1'b0;
  end

  // behavioural reference and measurement, updated on each rising edge
  always @(posedge clk) begin
    bit irqNext;
    if (!rst_n) begin
      pReg = 0; dReg = 0; run = 0; expPwm = 0; expIrq = 0; mLeft = 0; sLeft = 0;
    end else begin
      if (periodIrq) begin
        lastTicks = ticksAcc; lastHigh = highAcc; ticksAcc = 0; highAcc = 0; irqCnt++;
      end
      if (tick) begin ticksAcc++; if (pwmOut) highAcc++; end
      irqNext = 0;
      if (stopReq) begin run = 0; expPwm = 0; end
      else if (startReq) begin
        run = 1; mLeft = pReg; sLeft = dReg; expPwm = 0; irqNext = 1;
      end else if (run && tick) begin
        expPwm = (sLeft > 0);
        if (mLeft == 0) begin mLeft = pReg; sLeft = dReg; irqNext = 1; end
        else begin mLeft--; if (sLeft > 0) sLeft--; end
      end
      expIrq = irqNext;
      if (periodWrEn) pReg = periodWrData;
      if (dutyWrEn) dReg = dutyWrData;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R4 pwmOut", pwmOut, expPwm);
      check("R2,R9 periodIrq", periodIrq, expIrq);
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic writeRegs(int p, int d);
    @(negedge clk);
    periodWrEn = 1; periodWrData = p[15:0]; dutyWrEn = 1; dutyWrData = d[15:0];
    @(negedge clk);
    periodWrEn = 0; dutyWrEn = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk); startReq = 1; @(negedge clk); startReq = 0;
  endtask

  task automatic waitIrq();
    do @(negedge clk); while (!periodIrq);
    @(posedge clk); #1;
  endtask

  task automatic measure(string req, int p, int d);
    int expHigh;
    expHigh = (d > p + 1) ? p + 1 : d;
    waitIrq();
    check({req, " period ticks"}, lastTicks, p + 1);
    check({req, " high ticks"}, lastHigh, expHigh);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 pwm in reset", pwmOut, 0);
    check("R1 irq in reset", periodIrq, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 pwm idle", pwmOut, 0);

    // R3 R4: basic run, ticks every cycle
    writeRegs(4, 2);
    tickOn = 1; tickDiv = 1;
    pulseStart();
    waitIrq(); waitIrq();
    measure("R3,R4 p4d2", 4, 2);
    measure("R3,R4 p4d2b", 4, 2);

    // R5: zero duty, ticks every 2 cycles
    tickDiv = 2;
    writeRegs(5, 0);
    waitIrq(); waitIrq();
    measure("R5 d0", 5, 0);

    // R6: duty equal to P+1, and far above
    tickDiv = 3;
    writeRegs(3, 4);
    waitIrq(); waitIrq();
    measure("R6 d=p+1", 3, 4);
    writeRegs(3, 1000);
    waitIrq(); waitIrq();
    measure("R6 d>>p", 3, 1000);
    measure("R6 d>>p again", 3, 1000);

    // R7: mid-period rewrite
    tickDiv = 1;
    writeRegs(6, 3);
    waitIrq(); waitIrq();
    repeat (3) @(negedge clk);
    writeRegs(2, 1);
    measure("R7 old values", 6, 3);
    measure("R7 new values", 2, 1);

    // R10: no ticks, everything holds
    tickOn = 0;
    repeat (2) @(negedge clk);
    begin
      int irqBefore; bit pwmBefore;
      irqBefore = irqCnt; pwmBefore = pwmOut;
      repeat (20) @(negedge clk);
      check("R10 pwm held", pwmOut, pwmBefore);
      check("R10 no irq", irqCnt, irqBefore);
    end

    // R8: stop then ticks, then restart
    writeRegs(5, 5);
    tickOn = 1; tickDiv = 1;
    waitIrq();
    repeat (2) @(negedge clk);
    stopReq = 1; startReq = 1; @(negedge clk); stopReq = 0; startReq = 0;
    @(negedge clk);
    check("R8 pwm low after stop", pwmOut, 0);
    begin
      int irqBefore;
      irqBefore = irqCnt;
      repeat (30) @(negedge clk);
      check("R8 no irq while stopped", irqCnt, irqBefore);
      check("R8 pwm stays low", pwmOut, 0);
    end
    writeRegs(7, 3);
    pulseStart();
    measure("R8 restart", 7, 3);
    measure("R8 restart b", 7, 3);

    // R9: widths with spaced ticks
    tickDiv = 2;
    writeRegs(0, 1);
    waitIrq(); waitIrq();
    begin
      int maxRun = 0, runLen = 0;
      repeat (40) begin
        @(negedge clk);
        runLen = periodIrq ? runLen + 1 : 0;
        if (runLen > maxRun) maxRun = runLen;
      end
      check("R9 irq width", maxRun, 1);
    end
    measure("R3,R6 p0d1", 0, 1);

    tickOn = 0;
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule